// File: doc/BRIEF.md
# Four-Channel Shadow-Buffered Pulse-Width Modulator

This block produces four independent pulse-width-modulated pins and is controlled over a simple register bus. The bus has an address, write data, a write strobe and combinational read data. Two global write-one-to-act registers start and stop channels, and a third register reports which channels are running. Every channel has its own register bank. The bank holds a power-of-two clock divider selection, an output polarity bit, a 16-bit period and a 16-bit duty value.

A stopped channel takes new duty and period values immediately. A running channel ignores writes to its live values. It takes new values through separate update registers instead, and copies them in only when its counter wraps. A period already in progress is therefore never cut short or stretched. All channels share one free-running divider counter, so each channel only chooses which divider tap advances its counter.

Top module: `pwm_bank`

## Requirements
- R1: Writing the enable register at offset 0x04 with bit n set starts channel n from the next cycle. Bits that are zero in that write leave the matching channels as they were.
- R2: Writing the disable register at offset 0x08 with bit n set stops channel n from the next cycle. Bits that are zero in that write leave the matching channels as they were.
- R3: Reading offset 0x0C returns bit n set for each running channel n. All other bits read zero. After reset no channel runs.
- R4: Channel n's bank starts at offset 0x200 + n*0x20. Within a bank, 0x00 is mode, 0x04 is live duty, 0x08 is duty update, 0x0C is live period and 0x10 is period update. Mode bits [3:0] are the divider selection and mode bit 9 is polarity; its other bits read zero. Every bank register reads back, and any unmapped offset reads zero.
- R5: Only the low 16 bits of the duty, period and update registers are stored. The upper 16 bits of a write are ignored and read back as zero.
- R6: A divider counter counts clock edges from reset. A channel with selection p advances its counter only on edges where that count modulo 2^p equals 2^p-1. Selections above 10 act as 10.
- R7: A running channel counts from 0 up to period-1 and then wraps to 0, and a period of 0 keeps the count at 0. The active level is present while count < duty, so duty >= period gives a constant active level and duty 0 gives none. The pin equals the active level XOR the polarity bit.
- R8: A stopped channel holds its count at 0 and drives its pin to the polarity bit. On enabling, it starts from count 0 with its current live values.
- R9: While a channel is stopped, a write to its live duty or period is visible in the live register from the next cycle.
- R10: While a channel runs, writes to its live duty and period registers are ignored.
- R11: A write to an update register marks that value pending. At a running channel's wrap, a pending value is copied into its live register and the pending mark is cleared. An update written in the same cycle as a wrap stays pending for the following wrap. Updates written while the channel is stopped wait for the first wrap after it starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | Channel pins, bit n is channel n |

## Verification
Two functions can land on the same edge: a running channel's wrap, which consumes the pending update, and a bus write to that channel's duty-update register. The bench follows the model's counter until channel 0 sits one step before its last count. It then writes a first update, and on the very wrap cycle writes a second one. Reading the live duty afterwards must show the first value. After one more full period it must show the second value, which proves the colliding write was neither lost nor applied early.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   localparam int ADR_ENA      = 'h004;
   localparam int ADR_DIS      = 'h008;
   localparam int ADR_STAT     = 'h00C;
   localparam int CH_BASE      = 'h200;
   localparam int STRIDE_LG    = 5;
   localparam int POL_BIT      = 9;

   typedef enum logic [2:0] {
      REG_NONE,
      REG_MODE,
      REG_DTY,
      REG_DUPD,
      REG_PRD,
      REG_PUPD
   } chreg_e;

   function automatic chreg_e decode_ch(input logic [STRIDE_LG-1:0] off);
      case (off)
         5'h00:   return REG_MODE;
         5'h04:   return REG_DTY;
         5'h08:   return REG_DUPD;
         5'h0C:   return REG_PRD;
         5'h10:   return REG_PUPD;
         default: return REG_NONE;
      endcase
   endfunction

endpackage

// File: rtl/pwm_bank_prediv.sv
module pwm_bank_prediv #(
   parameter int MAX_SEL = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [MAX_SEL:0] tick
);

   logic [MAX_SEL-1:0] dcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) dcnt <= '0;
      else        dcnt <= dcnt + 1'b1;
   end

   for (genvar k = 0; k <= MAX_SEL; k++) begin : g_tap
      if (k == 0) begin : g_full
         assign tick[k] = 1'b1;
      end else begin : g_div
         assign tick[k] = &dcnt[k-1:0];
      end
   end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
   parameter int CNT_W   = 16,
   parameter int MAX_SEL = 10,
   parameter int SEL_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [MAX_SEL:0] tick_vec,
   input  logic [SEL_W-1:0] sel,
   input  logic             pol,
   input  logic             wr_dty,
   input  logic             wr_dupd,
   input  logic             wr_prd,
   input  logic             wr_pupd,
   input  logic [CNT_W-1:0] wdat,
   output logic             pin,
   output logic             wrap,
   output logic [CNT_W-1:0] dty_q,
   output logic [CNT_W-1:0] dupd_q,
   output logic [CNT_W-1:0] prd_q,
   output logic [CNT_W-1:0] pupd_q
);

   localparam logic [SEL_W-1:0] SEL_CAP = SEL_W'(MAX_SEL);

   logic [CNT_W-1:0] cnt;
   logic             dpend, ppend;
   logic [SEL_W-1:0] sel_c;
   logic             step, last;

   assign sel_c = (sel > SEL_CAP) ? SEL_CAP : sel;
   assign step  = tick_vec[sel_c];
   assign last  = ({1'b0, cnt} + 1'b1) >= {1'b0, prd_q};
   assign wrap  = en & step & last;
   assign pin   = (en & (cnt < dty_q)) ^ pol;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         dty_q  <= '0;
         prd_q  <= '0;
         dupd_q <= '0;
         pupd_q <= '0;
         dpend  <= 1'b0;
         ppend  <= 1'b0;
      end else begin
         if (!en)       cnt <= '0;
         else if (step) cnt <= last ? '0 : cnt + 1'b1;

         if (wr_dty && !en)       dty_q <= wdat;
         else if (wrap && dpend)  dty_q <= dupd_q;
         if (wr_prd && !en)       prd_q <= wdat;
         else if (wrap && ppend)  prd_q <= pupd_q;

         if (wr_dupd) begin
            dupd_q <= wdat;
            dpend  <= 1'b1;
         end else if (wrap) begin
            dpend  <= 1'b0;
         end
         if (wr_pupd) begin
            pupd_q <= wdat;
            ppend  <= 1'b1;
         end else if (wrap) begin
            ppend  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int CNT_W   = 16,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 12,
   parameter int MAX_SEL = 10,
   parameter int SEL_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);

   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
      $error("pwm_bank: NUM_CH must lie in 1..8");
   end
   if (CNT_W > DATA_W || SEL_W > POL_BIT || DATA_W <= POL_BIT) begin : g_bad_w
      $error("pwm_bank: field widths do not fit the data word");
   end
   if (MAX_SEL < 1 || MAX_SEL >= (1 << SEL_W)) begin : g_bad_sel
      $error("pwm_bank: MAX_SEL must be reachable by the selection field");
   end
   if (ADDR_W < 10) begin : g_bad_a
      $error("pwm_bank: address too narrow for channel banks");
   end

   logic [ADDR_W-1:0] ch_off;
   logic              in_ch;
   logic [IDX_W-1:0]  ch_idx;
   chreg_e            ch_reg;
   logic              wr_ena, wr_dis;
   logic [NUM_CH-1:0] ch_hit;

   logic [NUM_CH-1:0] chan_en;
   logic [NUM_CH-1:0] mode_pol;
   logic [SEL_W-1:0]  mode_sel [NUM_CH];
   logic [NUM_CH-1:0] chan_wrap;
   logic [CNT_W-1:0]  dty_q  [NUM_CH];
   logic [CNT_W-1:0]  dupd_q [NUM_CH];
   logic [CNT_W-1:0]  prd_q  [NUM_CH];
   logic [CNT_W-1:0]  pupd_q [NUM_CH];
   logic [MAX_SEL:0]  tick_vec;

   assign ch_off = bus_addr - ADDR_W'(CH_BASE);
   assign in_ch  = (bus_addr >= ADDR_W'(CH_BASE)) &&
                   ((ch_off >> STRIDE_LG) < ADDR_W'(NUM_CH));
   assign ch_idx = ch_off[STRIDE_LG +: IDX_W];
   assign ch_reg = decode_ch(ch_off[STRIDE_LG-1:0]);
   assign wr_ena = bus_we && (bus_addr == ADDR_W'(ADR_ENA));
   assign wr_dis = bus_we && (bus_addr == ADDR_W'(ADR_DIS));

   always_comb begin
      for (int i = 0; i < NUM_CH; i++) begin
         ch_hit[i] = bus_we && in_ch && (ch_idx == IDX_W'(i));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chan_en  <= '0;
         mode_pol <= '0;
         for (int i = 0; i < NUM_CH; i++) mode_sel[i] <= '0;
      end else begin
         if (wr_ena)      chan_en <= chan_en | bus_wdata[NUM_CH-1:0];
         else if (wr_dis) chan_en <= chan_en & ~bus_wdata[NUM_CH-1:0];
         for (int i = 0; i < NUM_CH; i++) begin
            if (ch_hit[i] && ch_reg == REG_MODE) begin
               mode_sel[i] <= bus_wdata[SEL_W-1:0];
               mode_pol[i] <= bus_wdata[POL_BIT];
            end
         end
      end
   end

   pwm_bank_prediv #(.MAX_SEL(MAX_SEL)) u_prediv (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_vec)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      pwm_bank_chan #(
         .CNT_W   (CNT_W),
         .MAX_SEL (MAX_SEL),
         .SEL_W   (SEL_W)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (chan_en[i]),
         .tick_vec (tick_vec),
         .sel      (mode_sel[i]),
         .pol      (mode_pol[i]),
         .wr_dty   (ch_hit[i] && ch_reg == REG_DTY),
         .wr_dupd  (ch_hit[i] && ch_reg == REG_DUPD),
         .wr_prd   (ch_hit[i] && ch_reg == REG_PRD),
         .wr_pupd  (ch_hit[i] && ch_reg == REG_PUPD),
         .wdat     (bus_wdata[CNT_W-1:0]),
         .pin      (pwm_out[i]),
         .wrap     (chan_wrap[i]),
         .dty_q    (dty_q[i]),
         .dupd_q   (dupd_q[i]),
         .prd_q    (prd_q[i]),
         .pupd_q   (pupd_q[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADR_STAT)) begin
         bus_rdata[NUM_CH-1:0] = chan_en;
      end else if (in_ch) begin
         case (ch_reg)
            REG_MODE: begin
               bus_rdata[SEL_W-1:0] = mode_sel[ch_idx];
               bus_rdata[POL_BIT]   = mode_pol[ch_idx];
            end
            REG_DTY:  bus_rdata[CNT_W-1:0] = dty_q[ch_idx];
            REG_DUPD: bus_rdata[CNT_W-1:0] = dupd_q[ch_idx];
            REG_PRD:  bus_rdata[CNT_W-1:0] = prd_q[ch_idx];
            REG_PUPD: bus_rdata[CNT_W-1:0] = pupd_q[ch_idx];
            default:  bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [NUM_CH-1:0] chan_en,
   input logic [NUM_CH-1:0] mode_pol,
   input logic [NUM_CH-1:0] pwm_out,
   input logic [NUM_CH-1:0] chan_wrap,
   input logic [CNT_W-1:0]  dty_q [NUM_CH],
   input logic [CNT_W-1:0]  prd_q [NUM_CH]
);

   logic is_ena, is_dis;
   assign is_ena = bus_we && (bus_addr == ADDR_W'(ADR_ENA));
   assign is_dis = bus_we && (bus_addr == ADDR_W'(ADR_DIS));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_a
      p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
         is_ena && bus_wdata[i] |=> chan_en[i]);

      p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
         is_dis && bus_wdata[i] |=> !chan_en[i]);

      p_zero_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (is_ena || is_dis) && !bus_wdata[i] |=> $stable(chan_en[i]));

      p_idle_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !chan_en[i] |-> pwm_out[i] == mode_pol[i]);

      p_dty_at_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
         chan_en[i] && $past(chan_en[i]) && !$stable(dty_q[i]) |-> $past(chan_wrap[i]));

      p_prd_at_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
         chan_en[i] && $past(chan_en[i]) && !$stable(prd_q[i]) |-> $past(chan_wrap[i]));
   end

endmodule

bind pwm_bank pwm_bank_chk #(
   .NUM_CH (NUM_CH),
   .CNT_W  (CNT_W),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .chan_en   (chan_en),
   .mode_pol  (mode_pol),
   .pwm_out   (pwm_out),
   .chan_wrap (chan_wrap),
   .dty_q     (dty_q),
   .prd_q     (prd_q)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic [3:0]  pwm_out;

   always #2 clk = ~clk;

   pwm_bank u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   string cur_req = "R8";
   int last_rd;

   int m_en[4], m_cnt[4], m_sel[4], m_pol[4];
   int m_dty[4], m_prd[4], m_du[4], m_pu[4], m_dp[4], m_pp[4];
   int m_div;

   task automatic check_eq(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int m_read(int a);
      int ch, off, r;
      r = 0;
      if (a == 'h0C) begin
         for (int c = 0; c < 4; c++) if (m_en[c] != 0) r |= (1 << c);
      end else if (a >= 'h200 && a < 'h280) begin
         ch = (a - 'h200) >> 5;
         off = (a - 'h200) & 31;
         case (off)
            'h00: r = m_sel[ch] | (m_pol[ch] << 9);
            'h04: r = m_dty[ch];
            'h08: r = m_du[ch];
            'h0C: r = m_prd[ch];
            'h10: r = m_pu[ch];
            default: r = 0;
         endcase
      end
      return r;
   endfunction

   function automatic int m_pins();
      int r, act;
      r = 0;
      for (int c = 0; c < 4; c++) begin
         act = (m_en[c] != 0 && m_cnt[c] < m_dty[c]) ? 1 : 0;
         if ((act ^ m_pol[c]) != 0) r |= (1 << c);
      end
      return r;
   endfunction

   task automatic m_step(bit we, int a, int d);
      int nen[4], ncnt[4], ndty[4], nprd[4], ndp[4], npp[4];
      int p, ch, off;
      for (int c = 0; c < 4; c++) begin
         nen[c] = m_en[c]; ncnt[c] = m_cnt[c];
         ndty[c] = m_dty[c]; nprd[c] = m_prd[c];
         ndp[c] = m_dp[c]; npp[c] = m_pp[c];
         p = (m_sel[c] > 10) ? 10 : m_sel[c];
         if (m_en[c] == 0) ncnt[c] = 0;
         else if ((m_div % (1 << p)) == (1 << p) - 1) begin
            if (m_cnt[c] + 1 >= m_prd[c]) begin
               ncnt[c] = 0;
               if (m_dp[c] != 0) begin ndty[c] = m_du[c]; ndp[c] = 0; end
               if (m_pp[c] != 0) begin nprd[c] = m_pu[c]; npp[c] = 0; end
            end else ncnt[c] = m_cnt[c] + 1;
         end
      end
      if (we) begin
         if (a == 'h04) begin
            for (int c = 0; c < 4; c++) if (d[c]) nen[c] = 1;
         end else if (a == 'h08) begin
            for (int c = 0; c < 4; c++) if (d[c]) nen[c] = 0;
         end else if (a >= 'h200 && a < 'h280) begin
            ch = (a - 'h200) >> 5;
            off = (a - 'h200) & 31;
            case (off)
               'h00: begin m_sel[ch] = d & 15; m_pol[ch] = (d >> 9) & 1; end
               'h04: if (m_en[ch] == 0) ndty[ch] = d & 'hFFFF;
               'h08: begin m_du[ch] = d & 'hFFFF; ndp[ch] = 1; end
               'h0C: if (m_en[ch] == 0) nprd[ch] = d & 'hFFFF;
               'h10: begin m_pu[ch] = d & 'hFFFF; npp[ch] = 1; end
               default: ;
            endcase
         end
      end
      for (int c = 0; c < 4; c++) begin
         m_en[c] = nen[c]; m_cnt[c] = ncnt[c];
         m_dty[c] = ndty[c]; m_prd[c] = nprd[c];
         m_dp[c] = ndp[c]; m_pp[c] = npp[c];
      end
      m_div++;
   endtask

   // one clock: drive at the falling edge, check read data before the
   // rising edge and the pins at the next falling edge
   task automatic cyc(bit we, int a, int d);
      bus_we = we;
      bus_addr = a[11:0];
      bus_wdata = d;
      #1;
      last_rd = bus_rdata;
      if (!we) check_eq({cur_req, " read"}, last_rd, m_read(a));
      m_step(we, a, d);
      @(negedge clk);
      check_eq({cur_req, " pins (R7)"}, int'(pwm_out), m_pins());
   endtask

   task automatic rd(int a, int exp, string tag);
      cyc(0, a, 0);
      check_eq(tag, last_rd, exp);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) cyc(0, 'h0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: got hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 4; c++) begin
         m_en[c] = 0; m_cnt[c] = 0; m_sel[c] = 0; m_pol[c] = 0;
         m_dty[c] = 0; m_prd[c] = 0; m_du[c] = 0; m_pu[c] = 0;
         m_dp[c] = 0; m_pp[c] = 0;
      end
      m_div = 0;
      repeat (3) @(negedge clk);
      check_eq("R8 reset pins", int'(pwm_out), 0);
      rst_n = 1'b1;
      cur_req = "R3";
      rd('h0C, 0, "R3 status after reset");

      // register map, 16-bit fields, direct writes while stopped
      cur_req = "R4";
      cyc(1, 'h220, 'h203);
      rd('h220, 'h203, "R4 mode readback");
      rd('h100, 0, "R4 unmapped");
      check_eq("R8 stopped pin follows polarity", int'(pwm_out[1]), 1);
      cur_req = "R5";
      cyc(1, 'h224, 'hABCD1234);
      rd('h224, 'h1234, "R5 upper bits dropped");
      cur_req = "R9";
      cyc(1, 'h200, 0);
      cyc(1, 'h20C, 6);
      cyc(1, 'h204, 3);
      rd('h20C, 6, "R9 period direct");
      rd('h204, 3, "R9 duty direct");

      // start and stop
      cur_req = "R1";
      cyc(1, 'h04, 1);
      rd('h0C, 1, "R1 channel 0 started");
      idle(14);
      cyc(1, 'h04, 4);
      rd('h0C, 5, "R1 zero bit keeps channel 0");
      cur_req = "R2";
      cyc(1, 'h08, 4);
      rd('h0C, 1, "R2 zero bit keeps channel 0");

      // running channel ignores live writes
      cur_req = "R10";
      cyc(1, 'h204, 9);
      rd('h204, 3, "R10 live duty unchanged");
      cyc(1, 'h20C, 2);
      rd('h20C, 6, "R10 live period unchanged");

      // update written on the wrap cycle itself
      cur_req = "R11";
      while (m_cnt[0] != 4) cyc(0, 'h0, 0);
      cyc(1, 'h208, 1);
      cyc(1, 'h208, 2);
      rd('h204, 1, "R11 first update at wrap");
      idle(7);
      rd('h204, 2, "R11 colliding update next wrap");
      cyc(1, 'h210, 4);
      idle(8);
      rd('h20C, 4, "R11 period update");

      // constant levels
      cur_req = "R7";
      cyc(1, 'h08, 1);
      check_eq("R8 stopped pin inactive", int'(pwm_out[0]), 0);
      cyc(1, 'h204, 9);
      cyc(1, 'h04, 1);
      idle(10);
      check_eq("R7 duty over period", int'(pwm_out[0]), 1);
      cyc(1, 'h08, 1);
      cyc(1, 'h204, 0);
      cyc(1, 'h04, 1);
      idle(10);
      check_eq("R7 duty zero", int'(pwm_out[0]), 0);
      cyc(1, 'h224, 5);
      cyc(1, 'h04, 2);
      idle(6);
      check_eq("R7 period zero inverted", int'(pwm_out[1]), 0);

      // restart from zero
      cur_req = "R8";
      cyc(1, 'h08, 1);
      cyc(1, 'h204, 3);
      cyc(1, 'h04, 1);
      check_eq("R8 restart begins active", int'(pwm_out[0]), 1);
      idle(12);

      // divider taps, including a clamped selection
      cur_req = "R6";
      cyc(1, 'h240, 2);
      cyc(1, 'h24C, 3);
      cyc(1, 'h244, 1);
      cyc(1, 'h260, 12);
      cyc(1, 'h26C, 2);
      cyc(1, 'h264, 1);
      rd('h260, 12, "R4 selection stored");
      cyc(1, 'h04, 'hC);
      idle(4200);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule